// File: doc/BRIEF.md
# Spike Source Lookup Engine

When a neuron fires elsewhere in the fabric, its 32-bit routing key arrives at this block. The block must find where the synaptic block for that source neuron lives in external memory. It walks a linked table of source entries held in a memory outside the block, reading one entry per step through a table read port. Each entry carries four fields: a match value, a selection mask, a base address and a link to another entry.

At every step the key is ANDed with the entry's mask, and the result is compared, unsigned, with the match value. Equal means a hit. A larger masked key follows the entry's link. A smaller one moves on to the next entry in index order. On a hit, the key bits outside the mask form an offset, and the block issues a DMA request for base plus offset with a fixed length of 48 bytes. That request is held until the DMA engine accepts it. A search ends in a miss pulse instead when it reaches an entry whose mask is all zero, or when it runs past a bound on the number of entries examined.

Keys can arrive while a search or a request is still in progress. Those keys are parked in a small last-in-first-out store. The most recently arrived key is always served first.

Top module: `spike_src_lookup`

## Requirements
- R1: After reset, `dma_valid`, `lk_miss` and `tbl_rd_en` are low and `key_ready` is high.
- R2: On an entry whose masked key (key AND mask) equals its match value, the block raises `dma_valid` with `dma_addr` = base + (key AND NOT mask) and `dma_len` = 48.
- R3: When the masked key is greater (unsigned) than the match value, the next table read uses the entry's link field as its index.
- R4: When the masked key is less than the match value, the next table read uses the current index plus one.
- R5: An entry whose mask is all zero ends the search with a one-cycle `lk_miss` pulse and no DMA request.
- R6: A search that examines 16 entries without a hit ends with `lk_miss` after exactly 16 table reads.
- R7: While `dma_valid` is high and `dma_ready` is low, `dma_valid` and `dma_addr` stay unchanged. After the handshake the request drops, and no table read happens while a request is pending.
- R8: Keys accepted while the block is busy are searched newest first.
- R9: With the key store holding 4 keys and the search busy, `key_ready` is low.
- R10: Every search starts by reading table entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Routing key offered |
| key_data | input | 32 | Routing key of the firing neuron |
| key_ready | output | 1 | Key accepted when high together with `key_valid` |
| tbl_rd_en | output | 1 | Table read strobe; the data returns on the next cycle |
| tbl_rd_idx | output | 5 | Index of the entry being read |
| tbl_match | input | 32 | Entry match value (read data) |
| tbl_mask | input | 32 | Entry selection mask (read data) |
| tbl_base | input | 32 | Entry synaptic region base address (read data) |
| tbl_link | input | 5 | Entry link index (read data) |
| dma_valid | output | 1 | DMA request pending |
| dma_ready | input | 1 | DMA engine accepts the request |
| dma_addr | output | 32 | Start address of the synaptic block |
| dma_len | output | 8 | Transfer length in bytes |
| lk_miss | output | 1 | One-cycle pulse when a search ends without a hit |

## Verification
The bench uses the default parameters: a 32-entry table, a step bound of 16 and a key store of depth 4. With these values, a self-linking table entry can drive a search all the way to the step bound within a few dozen cycles. Four parked keys are enough to fill the store, so the newest-first order and the back-pressure on `key_ready` both become observable. The bench's table model holds entries with two different mask widths, so both the offset formation and each of the three compare branches show up in the recorded read-index sequence.

// File: rtl/srclk_pkg.sv
package srclk_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_EVAL  = 2'd2,
    WK_REQ   = 2'd3
  } walk_state_e;
endpackage

// File: rtl/srclk_key_stack.sv
module srclk_key_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     slot_q [DEPTH];
  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;
  logic [PTR_W-1:0] wr_ptr, top_ptr;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign wr_ptr  = PTR_W'(count_q);
  assign top_ptr = PTR_W'(count_q - CNT_W'(1));
  assign top_data = slot_q[top_ptr];

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    if (push && !full) begin
      count_d  = count_q + CNT_W'(1);
      count_en = 1'b1;
    end else if (pop && !empty) begin
      count_d  = count_q - CNT_W'(1);
      count_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !full && (wr_ptr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q[g] <= push_data;
    end
  end
endmodule

// File: rtl/srclk_entry_cmp.sv
module srclk_entry_cmp #(
  parameter int KEY_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [KEY_W-1:0]  key,
  input  logic [KEY_W-1:0]  match_val,
  input  logic [KEY_W-1:0]  sel_mask,
  input  logic [ADDR_W-1:0] base,
  output logic              is_end,
  output logic              is_hit,
  output logic              is_greater,
  output logic [ADDR_W-1:0] start_addr
);
  logic [KEY_W-1:0] masked_key;
  logic [KEY_W-1:0] offset;

  assign masked_key = key & sel_mask;
  assign offset     = key & ~sel_mask;
  assign is_end     = (sel_mask == '0);
  assign is_hit     = !is_end && (masked_key == match_val);
  assign is_greater = (masked_key > match_val);
  assign start_addr = base + ADDR_W'(offset);
endmodule

// File: rtl/srclk_walker.sv
module srclk_walker
  import srclk_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 5,
  parameter int LEN_W     = 8,
  parameter int MAX_STEPS = 16,
  parameter int BLK_BYTES = 48,
  parameter int ROOT_IDX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_have,
  input  logic [KEY_W-1:0]  src_key,
  output logic              src_take,
  output logic              tbl_rd_en,
  output logic [IDX_W-1:0]  tbl_rd_idx,
  input  logic [KEY_W-1:0]  tbl_match,
  input  logic [KEY_W-1:0]  tbl_mask,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  tbl_link,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic              lk_miss
);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  walk_state_e       state_q, state_d;
  logic [KEY_W-1:0]  key_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [STEP_W-1:0] steps_q, steps_d;
  logic [ADDR_W-1:0] addr_q;
  logic              miss_q, miss_d;
  logic              key_en, idx_en, steps_en, addr_en;

  logic              c_end, c_hit, c_gt;
  logic [ADDR_W-1:0] c_addr;

  srclk_entry_cmp #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_cmp (
    .key        (key_q),
    .match_val  (tbl_match),
    .sel_mask   (tbl_mask),
    .base       (tbl_base),
    .is_end     (c_end),
    .is_hit     (c_hit),
    .is_greater (c_gt),
    .start_addr (c_addr)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    steps_d   = steps_q;
    miss_d    = 1'b0;
    key_en    = 1'b0;
    idx_en    = 1'b0;
    steps_en  = 1'b0;
    addr_en   = 1'b0;
    src_take  = 1'b0;
    tbl_rd_en = 1'b0;
    unique case (state_q)
      WK_IDLE: begin
        if (src_have) begin
          src_take = 1'b1;
          key_en   = 1'b1;
          idx_d    = IDX_W'(ROOT_IDX);
          idx_en   = 1'b1;
          steps_d  = '0;
          steps_en = 1'b1;
          state_d  = WK_FETCH;
        end
      end
      WK_FETCH: begin
        tbl_rd_en = 1'b1;
        steps_d   = steps_q + STEP_W'(1);
        steps_en  = 1'b1;
        state_d   = WK_EVAL;
      end
      WK_EVAL: begin
        if (c_end) begin
          miss_d  = 1'b1;
          state_d = WK_IDLE;
        end else if (c_hit) begin
          addr_en = 1'b1;
          state_d = WK_REQ;
        end else if (steps_q >= STEP_W'(MAX_STEPS)) begin
          miss_d  = 1'b1;
          state_d = WK_IDLE;
        end else begin
          idx_en  = 1'b1;
          idx_d   = c_gt ? tbl_link : (idx_q + IDX_W'(1));
          state_d = WK_FETCH;
        end
      end
      WK_REQ: begin
        if (dma_ready) state_d = WK_IDLE;
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        steps_q <= '0;
    else if (steps_en) steps_q <= steps_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk) begin
    if (key_en)  key_q  <= src_key;
    if (addr_en) addr_q <= c_addr;
  end

  assign tbl_rd_idx = idx_q;
  assign dma_valid  = (state_q == WK_REQ);
  assign dma_addr   = addr_q;
  assign dma_len    = LEN_W'(BLK_BYTES);
  assign lk_miss    = miss_q;
endmodule

// File: rtl/spike_src_lookup.sv
module spike_src_lookup #(
  parameter int KEY_W       = 32,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 5,
  parameter int LEN_W       = 8,
  parameter int MAX_STEPS   = 16,
  parameter int BLK_BYTES   = 48,
  parameter int STACK_DEPTH = 4,
  parameter int ROOT_IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key_data,
  output logic              key_ready,
  output logic              tbl_rd_en,
  output logic [IDX_W-1:0]  tbl_rd_idx,
  input  logic [KEY_W-1:0]  tbl_match,
  input  logic [KEY_W-1:0]  tbl_mask,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]  tbl_link,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic              lk_miss
);
  logic             st_empty, st_full, st_push, st_pop;
  logic [KEY_W-1:0] st_top;
  logic             src_have, src_take;
  logic [KEY_W-1:0] src_key;

  // A live key goes straight to an idle walker; otherwise it is parked.
  assign src_have  = key_valid || !st_empty;
  assign src_key   = key_valid ? key_data : st_top;
  assign key_ready = !st_full || src_take;
  assign st_push   = key_valid && !src_take && !st_full;
  assign st_pop    = src_take && !key_valid;

  srclk_key_stack #(.W(KEY_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_push),
    .push_data (key_data),
    .pop       (st_pop),
    .top_data  (st_top),
    .empty     (st_empty),
    .full      (st_full)
  );

  srclk_walker #(
    .KEY_W(KEY_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W),
    .MAX_STEPS(MAX_STEPS), .BLK_BYTES(BLK_BYTES), .ROOT_IDX(ROOT_IDX)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_have   (src_have),
    .src_key    (src_key),
    .src_take   (src_take),
    .tbl_rd_en  (tbl_rd_en),
    .tbl_rd_idx (tbl_rd_idx),
    .tbl_match  (tbl_match),
    .tbl_mask   (tbl_mask),
    .tbl_base   (tbl_base),
    .tbl_link   (tbl_link),
    .dma_valid  (dma_valid),
    .dma_ready  (dma_ready),
    .dma_addr   (dma_addr),
    .dma_len    (dma_len),
    .lk_miss    (lk_miss)
  );
endmodule

// File: rtl/srclk_checker.sv
module srclk_checker #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 8,
  parameter int MAX_STEPS = 16,
  parameter int BLK_BYTES = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tbl_rd_en,
  input logic              dma_valid,
  input logic              dma_ready,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [LEN_W-1:0]  dma_len,
  input logic              lk_miss
);
  localparam int CNT_W = $clog2(MAX_STEPS + 2);
  logic [CNT_W-1:0] reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            reads_q <= '0;
    else if (lk_miss || (dma_valid && dma_ready)) reads_q <= '0;
    else if (tbl_rd_en)                    reads_q <= reads_q + CNT_W'(1);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr))); // R7
  AST_NO_READ_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> !tbl_rd_en); // R7
  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> !lk_miss); // R5
  AST_MISS_EXCL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_miss && dma_valid)); // R5
  AST_LEN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> (dma_len == LEN_W'(BLK_BYTES))); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= CNT_W'(MAX_STEPS)); // R6
  AST_READ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> !tbl_rd_en); // R3
endmodule

bind spike_src_lookup srclk_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_STEPS(MAX_STEPS), .BLK_BYTES(BLK_BYTES)
) u_srclk_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tbl_rd_en (tbl_rd_en),
  .dma_valid (dma_valid),
  .dma_ready (dma_ready),
  .dma_addr  (dma_addr),
  .dma_len   (dma_len),
  .lk_miss   (lk_miss)
);

// File: tb/tb_spike_src_lookup.sv
`timescale 1ns/100ps
module tb_spike_src_lookup;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_valid;
  logic [31:0] key_data;
  logic        key_ready;
  logic        tbl_rd_en;
  logic [4:0]  tbl_rd_idx;
  logic [31:0] tbl_match, tbl_mask, tbl_base;
  logic [4:0]  tbl_link;
  logic        dma_valid, dma_ready;
  logic [31:0] dma_addr;
  logic [7:0]  dma_len;
  logic        lk_miss;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] t_match [32];
  logic [31:0] t_mask  [32];
  logic [31:0] t_base  [32];
  logic [4:0]  t_link  [32];

  int          rd_cnt;
  logic [4:0]  rd_log [64];

  always #2.5 clk = ~clk;

  spike_src_lookup dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_data(key_data),
    .key_ready(key_ready), .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
    .tbl_match(tbl_match), .tbl_mask(tbl_mask), .tbl_base(tbl_base),
    .tbl_link(tbl_link), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_addr(dma_addr), .dma_len(dma_len), .lk_miss(lk_miss)
  );

  // Table memory model: one-cycle read latency.
  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_match <= t_match[tbl_rd_idx];
      tbl_mask  <= t_mask[tbl_rd_idx];
      tbl_base  <= t_base[tbl_rd_idx];
      tbl_link  <= t_link[tbl_rd_idx];
      if (rd_cnt < 64) rd_log[rd_cnt] <= tbl_rd_idx;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic set_entry(input int i, input logic [31:0] m, input logic [31:0] k,
                           input logic [31:0] b, input logic [4:0] l);
    t_match[i] = m; t_mask[i] = k; t_base[i] = b; t_link[i] = l;
  endtask

  task automatic send_key(input logic [31:0] k);
    @(negedge clk);
    key_valid = 1'b1;
    key_data  = k;
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  // Waits at negedges for a request or a miss; hit=1 means request seen.
  task automatic wait_outcome(output bit hit, output bit miss);
    hit = 0; miss = 0;
    for (int i = 0; i < 200; i++) begin
      if (dma_valid) begin hit = 1; return; end
      if (lk_miss)   begin miss = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic lookup_hit(input logic [31:0] k, input logic [31:0] exp_addr,
                            input string req);
    bit h, m;
    @(negedge clk); rd_cnt = 0;
    send_key(k);
    wait_outcome(h, m);
    chk(h && !m, req, {31'd0, h}, 32'd1);
    chk(dma_addr == exp_addr, req, dma_addr, exp_addr);
    chk(dma_len == 8'd48, "R2", {24'd0, dma_len}, 32'd48);
    @(negedge clk);
  endtask

  task automatic lookup_miss(input logic [31:0] k, input int exp_reads, input string req);
    bit h, m;
    @(negedge clk); rd_cnt = 0;
    send_key(k);
    wait_outcome(h, m);
    chk(m && !h, req, {31'd0, m}, 32'd1);
    chk(rd_cnt == exp_reads, req, rd_cnt, exp_reads);
    @(negedge clk);
    chk(!lk_miss && !dma_valid, "R5", {30'd0, lk_miss, dma_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk(key_ready && !dma_valid && !lk_miss && !tbl_rd_en, "R1",
        {28'd0, key_ready, dma_valid, lk_miss, tbl_rd_en}, 32'h8);
  endtask

  task automatic t_less_then_hit;  // R4, R10
    lookup_hit(32'h0003_0030, 32'h0010_0430, "R2");
    chk(rd_cnt == 2 && rd_log[0] == 5'd0, "R10", {27'd0, rd_log[0]}, 32'd0);
    chk(rd_log[1] == 5'd1, "R4", {27'd0, rd_log[1]}, 32'd1);
  endtask

  task automatic t_greater_jump;  // R3
    lookup_hit(32'h0007_0010, 32'h0020_0010, "R3");
    chk(rd_cnt == 2 && rd_log[1] == 5'd4, "R3", {27'd0, rd_log[1]}, 32'd4);
  endtask

  task automatic t_narrow_mask;  // R2, R3
    lookup_hit(32'h0009_0ABC, 32'h0030_0ABC, "R2");
    chk(rd_cnt == 3 && rd_log[2] == 5'd8, "R3", {27'd0, rd_log[2]}, 32'd8);
  endtask

  task automatic t_sentinel;  // R5
    lookup_miss(32'h0006_0000, 3, "R5");
    chk(rd_log[2] == 5'd5, "R4", {27'd0, rd_log[2]}, 32'd5);
    lookup_miss(32'h0002_0000, 3, "R5");
    chk(rd_log[2] == 5'd2, "R4", {27'd0, rd_log[2]}, 32'd2);
  endtask

  task automatic t_step_limit;  // R6
    lookup_miss(32'h0020_0000, 16, "R6");
    chk(rd_log[15] == 5'd10, "R6", {27'd0, rd_log[15]}, 32'd10);
  endtask

  task automatic t_hold;  // R7
    bit h, m;
    dma_ready = 1'b0;
    send_key(32'h0003_0008);
    wait_outcome(h, m);
    chk(h, "R7", {31'd0, h}, 32'd1);
    rd_cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(dma_valid && dma_addr == 32'h0010_0408, "R7", dma_addr, 32'h0010_0408);
    end
    chk(rd_cnt == 0, "R7", rd_cnt, 32'd0);
    dma_ready = 1'b1;
    @(negedge clk);
    chk(!dma_valid, "R7", {31'd0, dma_valid}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_lifo;  // R8, R9
    bit h, m;
    logic [31:0] got [5];
    int n;
    dma_ready = 1'b0;
    send_key(32'h0003_0001);
    wait_outcome(h, m);
    for (int i = 2; i <= 5; i++) send_key(32'h0003_0000 | 32'(i));
    @(negedge clk);
    key_valid = 1'b1; key_data = 32'h0003_0006;
    #0.5;
    chk(!key_ready, "R9", {31'd0, key_ready}, 32'd0);
    key_valid = 1'b0;
    chk(dma_addr == 32'h0010_0401, "R8", dma_addr, 32'h0010_0401);
    dma_ready = 1'b1;
    n = 0;
    for (int c = 0; c < 100 && n < 5; c++) begin
      if (dma_valid) begin got[n] = dma_addr; n++; end
      @(negedge clk);
    end
    chk(n == 5, "R8", n, 32'd5);
    chk(got[0] == 32'h0010_0401, "R8", got[0], 32'h0010_0401);
    for (int j = 1; j < 5; j++)
      chk(got[j] == 32'h0010_0400 + 32'(6 - j), "R8", got[j], 32'h0010_0400 + 32'(6 - j));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) set_entry(i, '0, '0, '0, '0);
    set_entry(0,  32'h0005_0000, 32'hFFFF_0000, 32'h0000_0000, 5'd4);
    set_entry(1,  32'h0003_0000, 32'hFFFF_0000, 32'h0010_0400, 5'd0);
    set_entry(4,  32'h0007_0000, 32'hFFFF_0000, 32'h0020_0000, 5'd8);
    set_entry(8,  32'h0009_0000, 32'hFFFF_F000, 32'h0030_0000, 5'd10);
    set_entry(10, 32'h000A_0000, 32'hFFFF_0000, 32'h0040_0000, 5'd10);
    rd_cnt = 0;
    key_valid = 1'b0; key_data = '0; dma_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_less_then_hit();
    t_greater_jump();
    t_narrow_mask();
    t_sentinel();
    t_step_limit();
    t_hold();
    t_lifo();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule